// File: doc/BRIEF.md
# Broadcast Channel Write-Address Generator

This block produces the host-memory write address for every data beat that arrives on a broadcast bus. The bus can carry up to 256 broadcast channels. The block keeps a separate address pointer for each channel. Before a new transfer on a channel, software loads that channel's pointer with a base address. Each beat that arrives for a channel takes the channel's current pointer as its write address, and the pointer then moves forward by one beat of 16 bytes. Beats for different channels may arrive in any interleaved order. Each channel keeps its own place through the interleave.

The block also marks every beat whose channel differs from the channel of the beat before it. The host bus needs a fresh address cycle for such a beat. Two interrupt requests are generated alongside: one when the bus reports end of event, and one when the transfer FIFO reports empty.

The pointers are held in a 256-entry storage array with a synchronous read, so each update is a read-modify-write pipeline. A bypass path serves a beat whose channel was written in the cycle just before, so back-to-back beats and fresh base loads are never lost.

Top module: `dma_addr_table`

## Requirements
- R1: While reset is held and on the first cycle after it, `wr_valid`, `new_addr_phase`, `irq_evt_done` and `irq_fifo_empty` are low.
- R2: A beat presented with `beat_valid` high is output two clock cycles later with `wr_valid` high. `wr_chan` equals the beat's channel and `wr_addr` is that channel's pointer value before the beat.
- R3: Each beat adds 16 to the pointer of its own channel only. When channels interleave, every channel continues from its own last value.
- R4: A base load (`base_ld` high) sets the pointer of `base_ch` to `base_addr`. The next beat on that channel is output with exactly that address.
- R5: If a base load and a beat name the same channel in the same cycle, the load takes effect first. That beat gets the new base, and the following beat gets base + 16.
- R6: Beats on one channel in consecutive cycles get consecutive addresses, 16 apart, with no beat skipped or repeated.
- R7: `new_addr_phase` is high with an output beat when the beat is the first since reset or its channel differs from the previous output beat's channel. It is low otherwise, and always low when `wr_valid` is low.
- R8: Beats on all 256 channel numbers are accepted and output. No channel is filtered.
- R9: `irq_evt_done` is high for exactly one cycle, one cycle after `evt_done` rises. It stays low while `evt_done` stays high.
- R10: `irq_fifo_empty` is high for exactly one cycle, one cycle after `fifo_empty` rises. It stays low while `fifo_empty` stays high.
- R11: A base load or a beat on one channel leaves the pointers of all other channels unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| base_ld | input | 1 | Load a base address into one channel pointer |
| base_ch | input | 8 | Channel whose pointer is loaded |
| base_addr | input | 32 | Base address to load |
| beat_valid | input | 1 | A data beat is present this cycle |
| beat_ch | input | 8 | Broadcast channel of the beat |
| evt_done | input | 1 | End-of-event level from the bus |
| fifo_empty | input | 1 | Transfer FIFO empty level |
| wr_valid | output | 1 | An output write address is valid |
| wr_addr | output | 32 | Host-memory write address for the beat |
| wr_chan | output | 8 | Channel of the output beat |
| new_addr_phase | output | 1 | The beat needs a new host-bus address cycle |
| irq_evt_done | output | 1 | One-cycle end-of-event interrupt request |
| irq_fifo_empty | output | 1 | One-cycle FIFO-empty interrupt request |

## Verification
An address result appears two cycles after its beat: one register stage holds the beat while the pointer is read, and the output register holds the result. A base load affects beats presented in the same cycle or later. An interrupt pulse appears one cycle after its input rises. The bench drives inputs and samples outputs on the falling edge. It keeps a 2-deep queue of expected address results and compares against the entry queued two steps before. Interrupts are compared against input levels remembered from one and two steps earlier.

// File: rtl/dat_pkg.sv
package dat_pkg;
  localparam int unsigned DAT_CH_W  = 8;
  localparam int unsigned DAT_NUM_CH = 1 << DAT_CH_W;
  localparam int unsigned DAT_PTR_W = 32;
  localparam int unsigned IRQ_EVT   = 0;
  localparam int unsigned IRQ_EMPTY = 1;
  localparam int unsigned IRQ_NUM   = 2;

  typedef logic [DAT_CH_W-1:0]  chan_t;
  typedef logic [DAT_PTR_W-1:0] ptr_t;

  function automatic ptr_t ptr_advance(input ptr_t cur, input int unsigned step_bytes);
    return cur + ptr_t'(step_bytes);
  endfunction

  function automatic logic phase_needed(input logic seen_before, input chan_t prev_ch,
                                        input chan_t this_ch);
    return !seen_before || (prev_ch != this_ch);
  endfunction
endpackage

// File: rtl/dat_ptr_ram.sv
module dat_ptr_ram
  import dat_pkg::*;
(
  input  logic  clk,
  input  logic  rd_en,
  input  chan_t rd_ch,
  output ptr_t  rd_data,
  input  logic  wb_en,
  input  chan_t wb_ch,
  input  ptr_t  wb_data,
  input  logic  ld_en,
  input  chan_t ld_ch,
  input  ptr_t  ld_data
);
  ptr_t mem [DAT_NUM_CH];

  // Two write ports; the base-load port is written last so it wins a collision.
  always_ff @(posedge clk) begin
    if (wb_en) mem[wb_ch] <= wb_data;
    if (ld_en) mem[ld_ch] <= ld_data;
    if (rd_en) rd_data <= mem[rd_ch];
  end
endmodule

// File: rtl/dat_beat_pipe.sv
module dat_beat_pipe
  import dat_pkg::*;
#(
  parameter int unsigned BEAT_BYTES = 16
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  beat_valid,
  input  chan_t beat_ch,
  input  logic  ld_en,
  input  chan_t ld_ch,
  input  ptr_t  ld_base,
  input  ptr_t  rd_data,
  output logic  wb_en,
  output chan_t wb_ch,
  output ptr_t  wb_data,
  output logic  wr_valid,
  output ptr_t  wr_addr,
  output chan_t wr_chan,
  output logic  new_addr_phase
);
  // Stage 1: beat waiting for its pointer read
  logic  s1_vld;
  chan_t s1_ch;
  // Bypass copies of the writes made at the previous edge
  logic  byp_ld_vld, byp_wb_vld;
  chan_t byp_ld_ch,  byp_wb_ch;
  ptr_t  byp_ld_data, byp_wb_data;
  // Channel-switch tracking
  logic  have_last;
  chan_t last_ch;
  // Named internal events for assertions
  logic  ld_hit, wb_hit, out_reloaded;
  ptr_t  cur_ptr, nxt_ptr;
  logic  s1_phase;

  always_comb begin
    ld_hit  = byp_ld_vld && (byp_ld_ch == s1_ch);
    wb_hit  = byp_wb_vld && (byp_wb_ch == s1_ch);
    if (ld_hit)      cur_ptr = byp_ld_data;
    else if (wb_hit) cur_ptr = byp_wb_data;
    else             cur_ptr = rd_data;
    nxt_ptr  = ptr_advance(cur_ptr, BEAT_BYTES);
    s1_phase = phase_needed(have_last, last_ch, s1_ch);
  end

  assign wb_en   = s1_vld;
  assign wb_ch   = s1_ch;
  assign wb_data = nxt_ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld      <= 1'b0;
      s1_ch       <= '0;
      byp_ld_vld  <= 1'b0;
      byp_ld_ch   <= '0;
      byp_ld_data <= '0;
      byp_wb_vld  <= 1'b0;
      byp_wb_ch   <= '0;
      byp_wb_data <= '0;
      have_last   <= 1'b0;
      last_ch     <= '0;
      wr_valid    <= 1'b0;
      wr_addr     <= '0;
      wr_chan     <= '0;
      new_addr_phase <= 1'b0;
      out_reloaded   <= 1'b0;
    end else begin
      s1_vld      <= beat_valid;
      s1_ch       <= beat_ch;
      byp_ld_vld  <= ld_en;
      byp_ld_ch   <= ld_ch;
      byp_ld_data <= ld_base;
      byp_wb_vld  <= s1_vld && !(ld_en && (ld_ch == s1_ch));
      byp_wb_ch   <= s1_ch;
      byp_wb_data <= nxt_ptr;
      wr_valid    <= s1_vld;
      new_addr_phase <= s1_vld && s1_phase;
      out_reloaded   <= s1_vld && ld_hit;
      if (s1_vld) begin
        wr_addr   <= cur_ptr;
        wr_chan   <= s1_ch;
        have_last <= 1'b1;
        last_ch   <= s1_ch;
      end
    end
  end

  AST_PHASE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |-> !new_addr_phase); // R7

  AST_SAME_CHAN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && $past(wr_valid) && (wr_chan == $past(wr_chan)) && !out_reloaded)
      |-> (wr_addr == $past(wr_addr) + ptr_t'(BEAT_BYTES))); // R6

  AST_SAME_CHAN_NO_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && $past(wr_valid) && (wr_chan == $past(wr_chan))) |-> !new_addr_phase); // R7

  AST_BYPASS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(byp_ld_vld && byp_wb_vld && (byp_ld_ch == byp_wb_ch))); // R5
endmodule

// File: rtl/dat_irq_edge.sv
module dat_irq_edge #(
  parameter int unsigned N_SRC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src,
  output logic [N_SRC-1:0] irq
);
  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    logic src_d;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        src_d  <= 1'b0;
        irq[g] <= 1'b0;
      end else begin
        src_d  <= src[g];
        irq[g] <= src[g] && !src_d;
      end
    end

    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq[g] |=> !irq[g]); // R9 R10

    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      irq[g] |-> $past(src[g])); // R9 R10
  end
endmodule

// File: rtl/dma_addr_table.sv
module dma_addr_table
  import dat_pkg::*;
#(
  parameter int unsigned BEAT_BYTES = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                base_ld,
  input  logic [DAT_CH_W-1:0]  base_ch,
  input  logic [DAT_PTR_W-1:0] base_addr,
  input  logic                beat_valid,
  input  logic [DAT_CH_W-1:0]  beat_ch,
  input  logic                evt_done,
  input  logic                fifo_empty,
  output logic                wr_valid,
  output logic [DAT_PTR_W-1:0] wr_addr,
  output logic [DAT_CH_W-1:0]  wr_chan,
  output logic                new_addr_phase,
  output logic                irq_evt_done,
  output logic                irq_fifo_empty
);
  ptr_t  rd_data, wb_data;
  logic  wb_en;
  chan_t wb_ch;
  logic [IRQ_NUM-1:0] irq_src, irq_out;

  dat_ptr_ram u_ram (
    .clk     (clk),
    .rd_en   (beat_valid),
    .rd_ch   (beat_ch),
    .rd_data (rd_data),
    .wb_en   (wb_en),
    .wb_ch   (wb_ch),
    .wb_data (wb_data),
    .ld_en   (base_ld),
    .ld_ch   (base_ch),
    .ld_data (base_addr)
  );

  dat_beat_pipe #(.BEAT_BYTES(BEAT_BYTES)) u_pipe (
    .clk            (clk),
    .rst_n          (rst_n),
    .beat_valid     (beat_valid),
    .beat_ch        (beat_ch),
    .ld_en          (base_ld),
    .ld_ch          (base_ch),
    .ld_base        (base_addr),
    .rd_data        (rd_data),
    .wb_en          (wb_en),
    .wb_ch          (wb_ch),
    .wb_data        (wb_data),
    .wr_valid       (wr_valid),
    .wr_addr        (wr_addr),
    .wr_chan        (wr_chan),
    .new_addr_phase (new_addr_phase)
  );

  always_comb begin
    irq_src = '0;
    irq_src[IRQ_EVT]   = evt_done;
    irq_src[IRQ_EMPTY] = fifo_empty;
  end

  dat_irq_edge #(.N_SRC(IRQ_NUM)) u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .src   (irq_src),
    .irq   (irq_out)
  );

  assign irq_evt_done   = irq_out[IRQ_EVT];
  assign irq_fifo_empty = irq_out[IRQ_EMPTY];

  AST_BEAT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(beat_valid, 2) |-> (wr_valid && (wr_chan == $past(beat_ch, 2)))); // R2

  AST_NO_GHOST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> $past(beat_valid, 2)); // R8

  AST_SWITCH_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && $past(wr_valid) && (wr_chan != $past(wr_chan))) |-> new_addr_phase); // R7
endmodule

// File: tb/dma_addr_table_bench.sv
module dma_addr_table_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_ld = 1'b0;
  logic [7:0]  base_ch = '0;
  logic [31:0] base_addr = '0;
  logic        beat_valid = 1'b0;
  logic [7:0]  beat_ch = '0;
  logic        evt_done = 1'b0;
  logic        fifo_empty = 1'b0;
  logic        wr_valid, new_addr_phase, irq_evt_done, irq_fifo_empty;
  logic [31:0] wr_addr;
  logic [7:0]  wr_chan;

  always #4 clk = ~clk; // 125 MHz

  dma_addr_table u_dma_addr_table (
    .clk(clk), .rst_n(rst_n), .base_ld(base_ld), .base_ch(base_ch), .base_addr(base_addr),
    .beat_valid(beat_valid), .beat_ch(beat_ch), .evt_done(evt_done), .fifo_empty(fifo_empty),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_chan(wr_chan), .new_addr_phase(new_addr_phase),
    .irq_evt_done(irq_evt_done), .irq_fifo_empty(irq_fifo_empty)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  // Reference model state
  logic [31:0] mdl_ptr [256];
  bit          mdl_have = 1'b0;
  int          mdl_last = 0;
  // Expected result queue: q0 = one step ago, q1 = two steps ago
  bit q0_v = 0, q1_v = 0;
  logic [31:0] q0_a = 0, q1_a = 0;
  int q0_c = 0, q1_c = 0;
  bit q0_p = 0, q1_p = 0;
  string q0_t = "", q1_t = "";
  bit ev_p1 = 0, ev_p2 = 0, em_p1 = 0, em_p2 = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input bit ld, input int lch, input logic [31:0] lbase,
                      input bit bv, input int bch, input bit ev, input bit em,
                      input string tag);
    bit nv; logic [31:0] na; bit np;
    @(negedge clk);
    // Address results due now come from two steps ago (R2)
    chk(wr_valid == q1_v, "R2 valid", longint'(wr_valid), longint'(q1_v));
    if (q1_v) begin
      chk(wr_addr == q1_a, q1_t, longint'(wr_addr), longint'(q1_a));
      chk(int'(wr_chan) == q1_c, "R2 chan", longint'(wr_chan), longint'(q1_c));
      chk(new_addr_phase == q1_p, "R7 phase", longint'(new_addr_phase), longint'(q1_p));
    end else begin
      chk(new_addr_phase == 1'b0, "R7 idle phase", longint'(new_addr_phase), 0);
    end
    chk(irq_evt_done == (ev_p1 && !ev_p2), "R9 irq", longint'(irq_evt_done),
        longint'(ev_p1 && !ev_p2));
    chk(irq_fifo_empty == (em_p1 && !em_p2), "R10 irq", longint'(irq_fifo_empty),
        longint'(em_p1 && !em_p2));
    // Model: base load first, then the beat
    if (ld) mdl_ptr[lch] = lbase;
    nv = bv; na = 0; np = 0;
    if (bv) begin
      na = mdl_ptr[bch];
      mdl_ptr[bch] = mdl_ptr[bch] + 32'd16;
      np = !mdl_have || (mdl_last != bch);
      mdl_have = 1'b1;
      mdl_last = bch;
    end
    q1_v = q0_v; q1_a = q0_a; q1_c = q0_c; q1_p = q0_p; q1_t = q0_t;
    q0_v = nv;   q0_a = na;   q0_c = bch;  q0_p = np;   q0_t = tag;
    ev_p2 = ev_p1; ev_p1 = ev; em_p2 = em_p1; em_p1 = em;
    base_ld = ld; base_ch = 8'(lch); base_addr = lbase;
    beat_valid = bv; beat_ch = 8'(bch);
    evt_done = ev; fifo_empty = em;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, evt_done, fifo_empty, "R2 idle");
  endtask

  function automatic logic [31:0] base_of(input int ch, input int gen);
    return 32'h1000_0000 + 32'(ch) * 32'h0001_0000 + 32'(gen) * 32'h0000_1000;
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs quiet in reset
    chk(!wr_valid && !new_addr_phase && !irq_evt_done && !irq_fifo_empty, "R1 reset",
        longint'({wr_valid, new_addr_phase, irq_evt_done, irq_fifo_empty}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!wr_valid && !new_addr_phase && !irq_evt_done && !irq_fifo_empty, "R1 after reset",
        longint'({wr_valid, new_addr_phase, irq_evt_done, irq_fifo_empty}), 0);

    // Load every channel (R4)
    for (int ch = 0; ch < 256; ch++) step(1, ch, base_of(ch, 0), 0, 0, 0, 0, "R4 load");
    // Two beats per channel across all channels (R8, R3, R6)
    for (int ch = 0; ch < 256; ch++) begin
      step(0, 0, 0, 1, ch, 0, 0, "R8 first beat");
      step(0, 0, 0, 1, ch, 0, 0, "R6 back-to-back");
    end
    // Interleaved channels, every one continues its own sequence (R3, R11)
    for (int i = 0; i < 400; i++)
      step(0, 0, 0, 1, (i * 37 + (i / 3)) % 256, 0, 0, "R3 interleave");
    // Reload some channels while beats run on others (R11, R4)
    for (int i = 0; i < 64; i++) begin
      step(1, i * 4, base_of(i * 4, 1), 1, i * 4 + 1, 0, 0, "R11 other channel");
      step(0, 0, 0, 1, i * 4, 0, 0, "R4 after load");
    end
    // Same-cycle load and beat on one channel (R5), with beats either side
    for (int i = 0; i < 32; i++) begin
      step(0, 0, 0, 1, 200 + (i % 8), 0, 0, "R5 before");
      step(1, 200 + (i % 8), base_of(i, 2), 1, 200 + (i % 8), 0, 0, "R5 same cycle");
      step(0, 0, 0, 1, 200 + (i % 8), 0, 0, "R5 after");
      step(1, 10, base_of(10, 3 + i), 0, 0, 0, 0, "R11 load only");
      step(0, 0, 0, 1, 10, 0, 0, "R4 reload");
    end
    // Interrupt edges (R9, R10): pulses, held levels, simultaneous
    step(0, 0, 0, 0, 0, 1, 0, "R9 rise");
    step(0, 0, 0, 0, 0, 1, 0, "R9 hold");
    step(0, 0, 0, 0, 0, 1, 1, "R10 rise");
    step(0, 0, 0, 0, 0, 0, 1, "R10 hold");
    step(0, 0, 0, 0, 0, 0, 0, "R9 fall");
    step(0, 0, 0, 1, 5, 1, 1, "R9 R10 both");
    step(0, 0, 0, 1, 5, 0, 0, "R6 with irq");
    for (int i = 0; i < 16; i++) step(0, 0, 0, i % 2, 3, i % 3 == 0, i % 2 == 0, "R9 toggle");
    idle(4);
    finish_run();
  end
endmodule